// File: doc/BRIEF.md
# Secondary Loop Master/Slave Role Arbiter

This block decides whether the secondary clock loop generates its own timing (master) or follows the clock of a redundant partner module (slave). The role request comes from one of two places. One is a shared control pin that also carries the serial-port frame signal. The other is a configuration bit. A select input chooses between them.

The pin is also used for serial transfers, so its level is trusted only after a long quiet window. During that window the level must not change and the serial clock must not toggle. The arbiter also watches the partner clock. A partner clock counts as valid only when it is toggling and an external frequency check reports that it lies inside the accepted offset window. The arbiter enters slave only with a valid partner clock, and it falls back to master as soon as the partner clock becomes invalid.

The outputs are the current role, the partner-valid flag and a four-bit status code. The status code combines the role with the current stage of the secondary loop. Every input and output is a plain level. The block has no streaming interface, so there is no back-pressure to handle.

Top module: `ms_role_arbiter`

## Requirements
- R1: After reset the role is master, the pin (not the register) is the request source, and the qualified pin level is high, which means master.
- R2: In pin mode, a qualified high pin requests master and a qualified low pin requests slave.
- R3: A new pin level is qualified only after it has stayed unchanged, with no serial-clock transition, for more than `QUAL_CYCLES` clock cycles. An excursion shorter than the window leaves the role unchanged.
- R4: Any serial-clock transition restarts the quiet window. A pin level held while the serial clock toggles does not change the role.
- R5: When `sel_register` is 1, `reg_slave_req` is the request (1 = slave, 0 = master), and the pin has no effect on the role. A register change reaches the role on the next clock edge.
- R6: The role becomes slave only when slave is requested and the partner clock is valid. A slave request made while the partner is invalid leaves the role at master.
- R7: The partner clock is valid only while `partner_in_window` is 1 and a rising edge of `partner_clk` has been seen within the last `PRESENCE_TIMEOUT` cycles. Losing validity returns the role to master on the next edge.
- R8: `loop_status` is 0000 when `loop_stage` is 0 (not locked). Otherwise, for `loop_stage` values 1, 2 and 3 (frequency acquisition, phase acquisition, tracking), it is `loop_stage` as master and `loop_stage`+3 (0100, 0101, 0110) as slave.
- R9: A master request returns the role from slave to master on the next edge after the request takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| role_pin | input | 1 | Shared role/frame pin; high = master, low = slave |
| ser_clk | input | 1 | Serial-port clock, watched for activity |
| sel_register | input | 1 | 1 = role taken from `reg_slave_req` |
| reg_slave_req | input | 1 | Register role bit, 1 = slave |
| partner_clk | input | 1 | Clock from the partner module |
| partner_in_window | input | 1 | Partner frequency offset lies inside the accepted window |
| loop_stage | input | 2 | Secondary loop stage: 0 unlocked, 1 freq acq, 2 phase acq, 3 tracking |
| role_is_slave | output | 1 | Current role, 1 = slave |
| partner_valid | output | 1 | Partner clock present and in window |
| loop_status | output | 4 | Secondary loop status code |

## Verification
The assertions are checked on every cycle. They cover the following:
- The role enters slave only after a cycle in which the partner was valid.
- An invalid partner, a register master request or a qualified high pin each forces master on the next edge.
- The qualified pin level only ever takes the synchronized pin value, and only on a cycle with no serial-clock edge.
- The status code always falls in the range that matches the role.

Only the bench scenarios can show the length of the quiet window. These scenarios cover a short excursion being discarded, serial activity holding off a change, and the partner-presence timeout expiring.

// File: rtl/msr_pkg.sv
`timescale 1ns/1ps
package msr_pkg;
  typedef enum logic {
    ROLE_MASTER = 1'b0,
    ROLE_SLAVE  = 1'b1
  } role_t;

  localparam logic [1:0] STAGE_UNLOCKED = 2'd0;
  localparam int unsigned SLAVE_CODE_OFFSET = 3;
endpackage

// File: rtl/msr_sync.sv
`timescale 1ns/1ps
module msr_sync #(
  parameter int unsigned WIDTH = 1,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  // Two-stage synchronizer, one chain per bit, each with its own reset level.
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic stage_a, stage_b;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_a <= RESET_VAL[b];
        stage_b <= RESET_VAL[b];
      end else begin
        stage_a <= async_in[b];
        stage_b <= stage_a;
      end
    end
    assign sync_out[b] = stage_b;
  end
endmodule

// File: rtl/msr_pin_qualifier.sv
`timescale 1ns/1ps
module msr_pin_qualifier #(
  parameter int unsigned QUAL_CYCLES = 20_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic sclk_edge,
  output logic qual_level
);
  localparam int unsigned CW = $clog2(QUAL_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(QUAL_CYCLES);

  logic          pin_prev;
  logic [CW-1:0] quiet_cnt;
  logic          restart;

  assign restart = (pin_s != pin_prev) || sclk_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_prev   <= 1'b1;
      quiet_cnt  <= '0;
      qual_level <= 1'b1;
    end else begin
      pin_prev <= pin_s;
      if (restart) begin
        quiet_cnt <= '0;
      end else if (quiet_cnt != LIMIT) begin
        quiet_cnt <= quiet_cnt + 1'b1;
      end else begin
        qual_level <= pin_s;  // window elapsed with no disturbance
      end
    end
  end
endmodule

// File: rtl/msr_partner_monitor.sv
`timescale 1ns/1ps
module msr_partner_monitor #(
  parameter int unsigned PRESENCE_TIMEOUT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic partner_s,
  input  logic in_window,
  output logic valid
);
  localparam int unsigned CW = $clog2(PRESENCE_TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(PRESENCE_TIMEOUT);

  logic          partner_prev;
  logic [CW-1:0] idle_cnt;
  logic          present;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      partner_prev <= 1'b0;
      idle_cnt     <= LIMIT;  // absent until first edge
    end else begin
      partner_prev <= partner_s;
      if (partner_s && !partner_prev) begin
        idle_cnt <= '0;
      end else if (idle_cnt != LIMIT) begin
        idle_cnt <= idle_cnt + 1'b1;
      end
    end
  end

  assign present = (idle_cnt != LIMIT);
  assign valid   = present && in_window;
endmodule

// File: rtl/msr_role_fsm.sv
`timescale 1ns/1ps
module msr_role_fsm
  import msr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slave_req,
  input  logic       partner_ok,
  input  logic [1:0] stage,
  output logic       is_slave,
  output logic [3:0] status
);
  role_t role_q, role_d;

  always_comb begin
    role_d = role_q;
    unique case (role_q)
      ROLE_MASTER: if (slave_req && partner_ok) role_d = ROLE_SLAVE;
      ROLE_SLAVE:  if (!slave_req || !partner_ok) role_d = ROLE_MASTER;
      default:     role_d = ROLE_MASTER;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) role_q <= ROLE_MASTER;
    else        role_q <= role_d;
  end

  assign is_slave = (role_q == ROLE_SLAVE);

  always_comb begin
    if (stage == STAGE_UNLOCKED)      status = 4'd0;
    else if (role_q == ROLE_SLAVE)    status = {2'b00, stage} + 4'(SLAVE_CODE_OFFSET);
    else                              status = {2'b00, stage};
  end
endmodule

// File: rtl/ms_role_arbiter.sv
`timescale 1ns/1ps
module ms_role_arbiter #(
  parameter int unsigned QUAL_CYCLES      = 20_000_000,
  parameter int unsigned PRESENCE_TIMEOUT = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       role_pin,
  input  logic       ser_clk,
  input  logic       sel_register,
  input  logic       reg_slave_req,
  input  logic       partner_clk,
  input  logic       partner_in_window,
  input  logic [1:0] loop_stage,
  output logic       role_is_slave,
  output logic       partner_valid,
  output logic [3:0] loop_status
);
  localparam int unsigned NSYNC = 3;
  localparam logic [NSYNC-1:0] SYNC_RST = 3'b001;  // pin idles high

  logic [NSYNC-1:0] raw_in, synced;
  logic pin_s, sclk_s, partner_s, sclk_prev, sclk_edge;
  logic qual_level, slave_req;

  assign raw_in = {partner_clk, ser_clk, role_pin};

  msr_sync #(.WIDTH(NSYNC), .RESET_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(raw_in), .sync_out(synced)
  );

  assign pin_s     = synced[0];
  assign sclk_s    = synced[1];
  assign partner_s = synced[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= sclk_s;
  end
  assign sclk_edge = sclk_s ^ sclk_prev;

  msr_pin_qualifier #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .sclk_edge(sclk_edge),
    .qual_level(qual_level)
  );

  msr_partner_monitor #(.PRESENCE_TIMEOUT(PRESENCE_TIMEOUT)) u_partner (
    .clk(clk), .rst_n(rst_n), .partner_s(partner_s),
    .in_window(partner_in_window), .valid(partner_valid)
  );

  // Pin low means slave; register bit high means slave.
  assign slave_req = sel_register ? reg_slave_req : !qual_level;

  msr_role_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .slave_req(slave_req), .partner_ok(partner_valid),
    .stage(loop_stage), .is_slave(role_is_slave), .status(loop_status)
  );
endmodule

// File: rtl/msr_role_checker.sv
`timescale 1ns/1ps
module msr_role_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       role_is_slave,
  input logic       partner_valid,
  input logic       sel_register,
  input logic       reg_slave_req,
  input logic [1:0] loop_stage,
  input logic [3:0] loop_status,
  input logic       qual_level,
  input logic       pin_s,
  input logic       sclk_edge
);
  assert_slave_needs_partner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(role_is_slave) |-> $past(partner_valid));

  assert_invalid_forces_master_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !partner_valid |=> !role_is_slave);

  assert_reg_master_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_register && !reg_slave_req) |=> !role_is_slave);

  assert_pin_master_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_register && qual_level) |=> !role_is_slave);

  assert_qual_needs_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_level != $past(qual_level)) |-> (!$past(sclk_edge) && $past(pin_s) == qual_level));

  assert_status_unlocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_stage == 2'd0) |-> (loop_status == 4'd0));

  assert_status_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_stage != 2'd0) |-> (role_is_slave ? (loop_status >= 4'd4 && loop_status <= 4'd6)
                                            : (loop_status >= 4'd1 && loop_status <= 4'd3)));
endmodule

bind ms_role_arbiter msr_role_checker u_role_checker (
  .clk(clk), .rst_n(rst_n), .role_is_slave(role_is_slave), .partner_valid(partner_valid),
  .sel_register(sel_register), .reg_slave_req(reg_slave_req), .loop_stage(loop_stage),
  .loop_status(loop_status), .qual_level(qual_level), .pin_s(pin_s), .sclk_edge(sclk_edge)
);

// File: tb/ms_role_arbiter_test.sv
`timescale 1ns/1ps
module ms_role_arbiter_test;
  localparam int unsigned QUAL = 64;
  localparam int unsigned TMO  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic role_pin = 1'b1, ser_clk = 1'b0, sel_register = 1'b0, reg_slave_req = 1'b0;
  logic partner_clk = 1'b0, partner_in_window = 1'b1;
  logic [1:0] loop_stage = 2'd3;
  logic role_is_slave, partner_valid;
  logic [3:0] loop_status;
  logic partner_en = 1'b0, sclk_en = 1'b0;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  ms_role_arbiter #(.QUAL_CYCLES(QUAL), .PRESENCE_TIMEOUT(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .role_pin(role_pin), .ser_clk(ser_clk),
    .sel_register(sel_register), .reg_slave_req(reg_slave_req),
    .partner_clk(partner_clk), .partner_in_window(partner_in_window),
    .loop_stage(loop_stage), .role_is_slave(role_is_slave),
    .partner_valid(partner_valid), .loop_status(loop_status)
  );

  always #2.5 clk = ~clk;  // 200 MHz

  // Partner clock: rising edge every 8 system cycles when enabled.
  initial forever begin
    #20;
    if (partner_en) partner_clk = ~partner_clk;
  end

  // Serial clock activity: a transition every 10 system cycles when enabled.
  initial forever begin
    #50;
    if (sclk_en) ser_clk = ~ser_clk;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic check_nib(input string req, input logic [3:0] act, input logic [3:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic t_reset;
    wait_cyc(2);
    check_bit("R1", role_is_slave, 1'b0, "role after reset");
    check_nib("R1", loop_status, 4'b0011, "status after reset (master tracking)");
  endtask

  task automatic t_pin_to_slave;
    partner_en = 1'b1;
    role_pin = 1'b0;
    wait_cyc(2 * QUAL + 20);
    check_bit("R2", partner_valid, 1'b1, "partner valid while toggling");
    check_bit("R2", role_is_slave, 1'b1, "qualified low pin gives slave");
    check_nib("R8", loop_status, 4'b0110, "slave tracking status");
  endtask

  task automatic t_status_codes;
    loop_stage = 2'd1; wait_cyc(1);
    check_nib("R8", loop_status, 4'b0100, "slave freq acq");
    loop_stage = 2'd2; wait_cyc(1);
    check_nib("R8", loop_status, 4'b0101, "slave phase acq");
    loop_stage = 2'd0; wait_cyc(1);
    check_nib("R8", loop_status, 4'b0000, "unlocked");
    loop_stage = 2'd3;
  endtask

  task automatic t_short_excursion;
    role_pin = 1'b1;
    wait_cyc(QUAL / 2);
    role_pin = 1'b0;
    wait_cyc(2 * QUAL + 20);
    check_bit("R3", role_is_slave, 1'b1, "short high excursion ignored");
  endtask

  task automatic t_window_loss;
    partner_in_window = 1'b0;
    wait_cyc(3);
    check_bit("R7", partner_valid, 1'b0, "out of window is invalid");
    check_bit("R7", role_is_slave, 1'b0, "out of window forces master");
    partner_in_window = 1'b1;
    wait_cyc(3);
    check_bit("R6", role_is_slave, 1'b1, "slave again with valid partner");
  endtask

  task automatic t_partner_stops;
    partner_en = 1'b0;
    wait_cyc(TMO + 20);
    check_bit("R7", partner_valid, 1'b0, "idle partner times out");
    check_bit("R7", role_is_slave, 1'b0, "idle partner forces master");
    check_nib("R8", loop_status, 4'b0011, "master tracking status");
    partner_en = 1'b1;
    wait_cyc(TMO + 20);
    check_bit("R6", role_is_slave, 1'b1, "partner returns, slave again");
  endtask

  task automatic t_sclk_activity;
    sclk_en = 1'b1;
    role_pin = 1'b1;
    wait_cyc(4 * QUAL);
    check_bit("R4", role_is_slave, 1'b1, "pin high during serial activity ignored");
    sclk_en = 1'b0;
    wait_cyc(2 * QUAL + 20);
    check_bit("R9", role_is_slave, 1'b0, "qualified high pin returns master");
  endtask

  task automatic t_no_partner_request;
    partner_en = 1'b0;
    wait_cyc(TMO + 20);
    role_pin = 1'b0;
    wait_cyc(2 * QUAL + 20);
    check_bit("R6", role_is_slave, 1'b0, "slave request without partner stays master");
    partner_en = 1'b1;
    wait_cyc(TMO + 20);
    check_bit("R6", role_is_slave, 1'b1, "partner appears, slave granted");
  endtask

  task automatic t_register_mode;
    sel_register = 1'b1;
    reg_slave_req = 1'b0;
    wait_cyc(2);
    check_bit("R5", role_is_slave, 1'b0, "register 0 means master despite low pin");
    reg_slave_req = 1'b1;
    wait_cyc(2);
    check_bit("R5", role_is_slave, 1'b1, "register 1 means slave");
    role_pin = 1'b1;
    wait_cyc(2 * QUAL + 20);
    check_bit("R5", role_is_slave, 1'b1, "pin ignored in register mode");
    reg_slave_req = 1'b0;
    wait_cyc(2);
    check_bit("R9", role_is_slave, 1'b0, "register master request returns master");
    sel_register = 1'b0;
    wait_cyc(3);
    check_bit("R2", role_is_slave, 1'b0, "back to pin mode, high pin master");
  endtask

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    t_reset();
    t_pin_to_slave();
    t_status_codes();
    t_short_excursion();
    t_window_loss();
    t_partner_stops();
    t_sclk_activity();
    t_no_partner_request();
    t_register_mode();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule